// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor

This block is a small single-accumulator processor with a unified memory for code and data. Every datapath register, the accumulator and every memory word are eight bits wide. One memory port serves both instruction fetch and data access through a request/acknowledge handshake. A separate input port supplies a byte to the accumulator. An output port presents the accumulator together with a one-cycle strobe. Arithmetic and logic results always land in the accumulator. A carry flag and a zero flag feed the conditional branches.

Instructions come in three lengths by class. Operations that read or write memory are two bytes: an opcode byte followed by an operand byte. The operand is resolved by one of four addressing modes: the value itself, a direct address, a pointer held in memory, or an offset from the stack pointer. Branches are also two bytes and carry their target in the second byte. Miscellaneous operations are a single byte.

A multi-cycle controller sequences the work. The state register starts in IDLE. FETCH reads the opcode, and DECODE either executes a one-byte operation or moves on. OPND reads the operand byte, and INDIR reads the pointer for indirect mode. READ fetches the data operand, WRITE stores the accumulator, EXEC updates the accumulator and flags, and HALT is final. The transitions are as follows:
- IDLE goes to FETCH.
- FETCH goes to DECODE on ack.
- DECODE goes to OPND for two-byte classes, to HALT for the halt opcode, and to FETCH otherwise.
- OPND goes to FETCH for branches, to EXEC for immediate operands, to WRITE for stores, to INDIR for indirect mode, and to READ otherwise.
- INDIR goes to READ or WRITE.
- READ goes to EXEC.
- WRITE goes to FETCH.
- EXEC goes to FETCH.

Top module: `acc_cpu`

## Requirements
- R1: Reset clears the program counter, accumulator and both flags, and loads the stack pointer with 0xFF. No memory request is made while reset is held. The first request after release is an opcode fetch from address 0x00.
- R2: Once the memory request is raised, the address, write enable and write data stay unchanged until ack is seen. Write enable is only ever raised together with the request.
- R3: The opcode byte holds the operation in bits [7:4] and the addressing mode in bits [1:0]. Operations 1 to 7 are memory-reference, 8 to A are branches, and all others are one byte long. The program counter steps past every byte it reads.
- R4: Mode 00 (immediate) uses the operand byte itself as the data value.
- R5: Mode 01 (direct) uses the operand byte as the data address.
- R6: Mode 10 (indirect) makes an extra read at the operand address and uses the byte returned as the data address.
- R7: Mode 11 uses (stack pointer + operand) modulo 256 as the data address. Opcode D (one byte) copies the accumulator into the stack pointer.
- R8: ADD (3) sets acc = acc + operand and ADC (4) sets acc = acc + operand + carry. Both write the carry-out to the carry flag. Every accumulator write sets the zero flag when the new value is 0x00.
- R9: LDA (1) loads the operand, and AND (5), OR (6) and XOR (7) combine the operand with the accumulator bitwise. None of these four alters the carry flag.
- R10: JMP (8) always loads the program counter with the operand byte. JC (9) does so when carry is set and JZ (A) when zero is set. Otherwise the program counter ends 2 past the opcode.
- R11: STA (2) writes the accumulator to the effective address. In immediate mode the operand byte is used as the address, as in direct mode.
- R12: IN (B) loads the input port into the accumulator. OUT (C) copies the accumulator to the output port and raises the output strobe for exactly one cycle. Opcodes 0 and E do nothing.
- R13: HLT (F) stops the processor for good. The halted output stays high and no further memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Write data (accumulator) |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| in_data | input | 8 | Input port byte |
| out_data | output | 8 | Output port byte |
| out_strobe | output | 1 | One-cycle pulse on a new output byte |
| halted | output | 1 | Processor has stopped |

## Verification
Some properties are checked on every cycle. The request fields must hold steady while an access waits for ack. Writes must never appear without a request. The program counter must never be both incremented and loaded at once. The output strobe must never last two cycles. The halt state must be sticky and silent. The addressing modes, the arithmetic with carry, the flag-dependent branches, the untouched carry after loads and logic operations, and the instruction lengths show up only in the results of the bench's directed programs. Those programs run under several memory latencies and are checked through stored bytes and output-port values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned OPC_W  = 4;
    localparam int unsigned MODE_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'h0,
        OP_LDA  = 4'h1,
        OP_STA  = 4'h2,
        OP_ADD  = 4'h3,
        OP_ADC  = 4'h4,
        OP_AND  = 4'h5,
        OP_OR   = 4'h6,
        OP_XOR  = 4'h7,
        OP_JMP  = 4'h8,
        OP_JC   = 4'h9,
        OP_JZ   = 4'hA,
        OP_IN   = 4'hB,
        OP_OUT  = 4'hC,
        OP_TAS  = 4'hD,
        OP_NOP2 = 4'hE,
        OP_HLT  = 4'hF
    } opcode_e;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM = 2'b00,
        AM_DIR = 2'b01,
        AM_IND = 2'b10,
        AM_SPR = 2'b11
    } amode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_OPND,
        S_INDIR,
        S_READ,
        S_WRITE,
        S_EXEC,
        S_HALT
    } state_e;

    typedef enum logic { AS_PC, AS_MAR } asel_e;
    typedef enum logic { MS_RDATA, MS_SPREL } msel_e;
    typedef enum logic [1:0] { AW_NONE, AW_ALU, AW_IN } accw_e;

    typedef struct packed {
        logic  mem_req;
        logic  mem_we;
        asel_e asel;
        logic  ir_ld;
        logic  pc_inc;
        logic  pc_load;
        logic  mar_ld;
        msel_e msel;
        logic  mdr_ld;
        accw_e accw;
        logic  out_ld;
        logic  sp_ld;
    } ctl_t;

    function automatic logic is_memref(opcode_e o);
        return (o >= OP_LDA) && (o <= OP_XOR);
    endfunction

    function automatic logic is_branch(opcode_e o);
        return (o >= OP_JMP) && (o <= OP_JZ);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  opcode_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   y,
    output logic            cout,
    output logic            carry_wr
);

    logic [DW:0] sum;
    logic        cin_eff;

    always_comb begin
        cin_eff  = (op == OP_ADC) ? cin : 1'b0;
        sum      = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin_eff};
        cout     = sum[DW];
        carry_wr = (op == OP_ADD) || (op == OP_ADC);
        unique case (op)
            OP_LDA:         y = b;
            OP_ADD, OP_ADC: y = sum[DW-1:0];
            OP_AND:         y = a & b;
            OP_OR:          y = a | b;
            OP_XOR:         y = a ^ b;
            default:        y = a;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ir,
    input  logic          mem_ack,
    input  logic          carry,
    input  logic          zero,
    output ctl_t          ctl,
    output logic          halted
);

    state_e  state;
    state_e  nxt;
    opcode_e op;
    amode_e  md;
    logic    taken;

    assign op     = opcode_e'(ir[DW-1 -: OPC_W]);
    assign md     = amode_e'(ir[MODE_W-1:0]);
    assign taken  = (op == OP_JMP) || ((op == OP_JC) && carry) || ((op == OP_JZ) && zero);
    assign halted = (state == S_HALT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = S_FETCH;
            S_FETCH:  if (mem_ack) nxt = S_DECODE;
            S_DECODE: begin
                if (is_memref(op) || is_branch(op)) nxt = S_OPND;
                else if (op == OP_HLT)              nxt = S_HALT;
                else                                nxt = S_FETCH;
            end
            S_OPND: begin
                if (mem_ack) begin
                    if (is_branch(op))      nxt = S_FETCH;
                    else if (md == AM_IMM)  nxt = (op == OP_STA) ? S_WRITE : S_EXEC;
                    else if (md == AM_IND)  nxt = S_INDIR;
                    else                    nxt = (op == OP_STA) ? S_WRITE : S_READ;
                end
            end
            S_INDIR:  if (mem_ack) nxt = (op == OP_STA) ? S_WRITE : S_READ;
            S_READ:   if (mem_ack) nxt = S_EXEC;
            S_WRITE:  if (mem_ack) nxt = S_FETCH;
            S_EXEC:   nxt = S_FETCH;
            S_HALT:   nxt = S_HALT;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH: begin
                ctl.mem_req = 1'b1;
                ctl.asel    = AS_PC;
                ctl.ir_ld   = mem_ack;
                ctl.pc_inc  = mem_ack;
            end
            S_DECODE: begin
                if (op == OP_IN)  ctl.accw   = AW_IN;
                if (op == OP_OUT) ctl.out_ld = 1'b1;
                if (op == OP_TAS) ctl.sp_ld  = 1'b1;
            end
            S_OPND: begin
                ctl.mem_req = 1'b1;
                ctl.asel    = AS_PC;
                if (mem_ack) begin
                    if (is_branch(op)) begin
                        ctl.pc_load = taken;
                        ctl.pc_inc  = !taken;
                    end else begin
                        ctl.pc_inc = 1'b1;
                        if (md == AM_IMM && op != OP_STA) begin
                            ctl.mdr_ld = 1'b1;
                        end else begin
                            ctl.mar_ld = 1'b1;
                            ctl.msel   = (md == AM_SPR) ? MS_SPREL : MS_RDATA;
                        end
                    end
                end
            end
            S_INDIR: begin
                ctl.mem_req = 1'b1;
                ctl.asel    = AS_MAR;
                ctl.mar_ld  = mem_ack;
                ctl.msel    = MS_RDATA;
            end
            S_READ: begin
                ctl.mem_req = 1'b1;
                ctl.asel    = AS_MAR;
                ctl.mdr_ld  = mem_ack;
            end
            S_WRITE: begin
                ctl.mem_req = 1'b1;
                ctl.mem_we  = 1'b1;
                ctl.asel    = AS_MAR;
            end
            S_EXEC:  ctl.accw = AW_ALU;
            default: ;
        endcase
    end

    // R13
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |=> (state == S_HALT));

    // R2
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |-> ctl.mem_req);

    // R10
    pc_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.pc_inc && ctl.pc_load));

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
    import acc_cpu_pkg::*;
#(
    parameter int unsigned   DW      = 8,
    parameter logic [DW-1:0] SP_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] ir,
    output logic          carry,
    output logic          zero,
    output logic [DW-1:0] out_data,
    output logic          out_strobe
);

    logic [DW-1:0] pc, mar, mdr, acc, sp;
    logic [DW-1:0] alu_y;
    logic          alu_co, alu_cw;
    logic [DW-1:0] mar_nxt;

    acc_alu #(.DW(DW)) u_alu (
        .op       (opcode_e'(ir[DW-1 -: OPC_W])),
        .a        (acc),
        .b        (mdr),
        .cin      (carry),
        .y        (alu_y),
        .cout     (alu_co),
        .carry_wr (alu_cw)
    );

    assign mem_addr  = (ctl.asel == AS_PC) ? pc : mar;
    assign mem_wdata = acc;
    assign mar_nxt   = (ctl.msel == MS_SPREL) ? (sp + mem_rdata) : mem_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            mar <= '0;
            mdr <= '0;
            sp  <= SP_INIT;
        end else begin
            if (ctl.pc_load)     pc <= mem_rdata;
            else if (ctl.pc_inc) pc <= pc + 1'b1;
            if (ctl.ir_ld)  ir  <= mem_rdata;
            if (ctl.mar_ld) mar <= mar_nxt;
            if (ctl.mdr_ld) mdr <= mem_rdata;
            if (ctl.sp_ld)  sp  <= acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            carry <= 1'b0;
            zero  <= 1'b0;
        end else if (ctl.accw == AW_ALU) begin
            acc  <= alu_y;
            zero <= (alu_y == '0);
            if (alu_cw) carry <= alu_co;
        end else if (ctl.accw == AW_IN) begin
            acc  <= in_data;
            zero <= (in_data == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_strobe <= 1'b0;
        end else begin
            out_strobe <= ctl.out_ld;
            if (ctl.out_ld) out_data <= acc;
        end
    end

    // R12
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned   DW      = 8,
    parameter logic [DW-1:0] SP_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] out_data,
    output logic          out_strobe,
    output logic          halted
);

    ctl_t          ctl;
    logic [DW-1:0] ir;
    logic          carry, zero;

    acc_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ir      (ir),
        .mem_ack (mem_ack),
        .carry   (carry),
        .zero    (zero),
        .ctl     (ctl),
        .halted  (halted)
    );

    acc_dpath #(.DW(DW), .SP_INIT(SP_INIT)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .in_data    (in_data),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .ir         (ir),
        .carry      (carry),
        .zero       (zero),
        .out_data   (out_data),
        .out_strobe (out_strobe)
    );

    assign mem_req = ctl.mem_req;
    assign mem_we  = ctl.mem_we;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R13
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_req, mem_we, mem_ack = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata = 8'h00;
    logic [7:0] in_data = 8'h00;
    logic [7:0] out_data;
    logic       out_strobe, halted;

    logic [7:0] img  [0:255];
    logic [7:0] mem  [0:255];
    logic [7:0] outs [0:15];
    int out_cnt = 0;
    int wr_cnt = 0;
    int viol = 0;
    int lat = 0;
    int wcnt = 0;
    int checks = 0;
    int errors = 0;

    logic       p_wait = 1'b0;
    logic       p_we = 1'b0;
    logic [7:0] p_addr = 8'h00, p_wdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .in_data(in_data), .out_data(out_data),
        .out_strobe(out_strobe), .halted(halted)
    );

    // memory model with programmable ack latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
            mem_ack <= 1'b0;
            wcnt    <= 0;
            wr_cnt  <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // output capture and handshake monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            out_cnt <= 0;
            viol    <= 0;
            p_wait  <= 1'b0;
        end else begin
            if (out_strobe && out_cnt < 16) begin
                outs[out_cnt] <= out_data;
                out_cnt <= out_cnt + 1;
            end
            if (p_wait && !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
                viol <= viol + 1;
            p_wait  <= mem_req && !mem_ack;
            p_addr  <= mem_addr;
            p_we    <= mem_we;
            p_wdata <= mem_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic put(input int a, input logic [7:0] v);
        img[a] = v;
    endtask

    task automatic wait_halt();
        int cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL R13: actual running expected halted");
        end
    endtask

    task automatic run_prog(input int lat_i);
        rst_n = 1'b0;
        lat   = lat_i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_halt();
    endtask

    task automatic t_reset();
        clear_img();
        put(8'h00, 8'hC0); put(8'h01, 8'h40); put(8'h02, 8'h00); put(8'h03, 8'hC0);
        put(8'h04, 8'h13); put(8'h05, 8'h0A); put(8'h06, 8'hC0); put(8'h07, 8'hF0);
        put(8'h09, 8'h77);
        rst_n = 1'b0;
        lat   = 1;
        repeat (3) @(negedge clk);
        chk("R1 no request in reset", mem_req, 0);
        chk("R1 strobe low in reset", out_strobe, 0);
        chk("R1 not halted in reset", halted, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 first request", mem_req, 1);
        chk("R1 first fetch address", mem_addr, 8'h00);
        wait_halt();
        chk("R1 output count", out_cnt, 3);
        chk("R1 acc reset zero", outs[0], 8'h00);
        chk("R1 carry reset zero", outs[1], 8'h00);
        chk("R1 R7 sp reset FF", outs[2], 8'h77);
    endtask

    task automatic t_imm_add();
        clear_img();
        put(8'h00, 8'h10); put(8'h01, 8'hF0); put(8'h02, 8'h30); put(8'h03, 8'h10);
        put(8'h04, 8'hC0); put(8'h05, 8'h40); put(8'h06, 8'h05); put(8'h07, 8'hC0);
        put(8'h08, 8'hF0);
        run_prog(0);
        chk("R8 output count", out_cnt, 2);
        chk("R4 R8 ADD wraps", outs[0], 8'h00);
        chk("R8 ADC adds carry", outs[1], 8'h06);
    endtask

    task automatic t_dir_ind_store();
        clear_img();
        put(8'h00, 8'h11); put(8'h01, 8'h20); put(8'h02, 8'h32); put(8'h03, 8'h21);
        put(8'h04, 8'h21); put(8'h05, 8'h30); put(8'h06, 8'h20); put(8'h07, 8'h31);
        put(8'h08, 8'h22); put(8'h09, 8'h23); put(8'h0A, 8'hF0);
        put(8'h20, 8'h33); put(8'h21, 8'h22); put(8'h22, 8'h44); put(8'h23, 8'h40);
        run_prog(3);
        chk("R5 R6 R11 direct store", mem[8'h30], 8'h77);
        chk("R11 immediate-mode store", mem[8'h31], 8'h77);
        chk("R6 R11 indirect store", mem[8'h40], 8'h77);
        chk("R6 pointer untouched", mem[8'h22], 8'h44);
        chk("R11 write count", wr_cnt, 3);
        chk("R2 handshake held stable", viol, 0);
    endtask

    task automatic t_sprel();
        clear_img();
        put(8'h00, 8'h10); put(8'h01, 8'h80); put(8'h02, 8'hD0); put(8'h03, 8'h13);
        put(8'h04, 8'h90); put(8'h05, 8'hC0); put(8'h06, 8'h10); put(8'h07, 8'hF0);
        put(8'h08, 8'hD0); put(8'h09, 8'h13); put(8'h0A, 8'h21); put(8'h0B, 8'hC0);
        put(8'h0C, 8'h23); put(8'h0D, 8'h22); put(8'h0E, 8'hF0);
        put(8'h10, 8'h5A); put(8'h11, 8'hA5);
        run_prog(2);
        chk("R7 output count", out_cnt, 2);
        chk("R7 sp-relative wrap load", outs[0], 8'h5A);
        chk("R7 sp reload", outs[1], 8'hA5);
        chk("R7 sp-relative store", mem[8'h12], 8'hA5);
    endtask

    task automatic t_branch();
        clear_img();
        put(8'h00, 8'h10); put(8'h01, 8'h00); put(8'h02, 8'hA0); put(8'h03, 8'h08);
        put(8'h04, 8'h10); put(8'h05, 8'hEE); put(8'h06, 8'hC0); put(8'h07, 8'hF0);
        put(8'h08, 8'h10); put(8'h09, 8'h01); put(8'h0A, 8'hA0); put(8'h0B, 8'h04);
        put(8'h0C, 8'h10); put(8'h0D, 8'hFF); put(8'h0E, 8'h30); put(8'h0F, 8'h01);
        put(8'h10, 8'h90); put(8'h11, 8'h18); put(8'h12, 8'h10); put(8'h13, 8'hBB);
        put(8'h14, 8'hC0); put(8'h15, 8'hF0);
        put(8'h18, 8'h10); put(8'h19, 8'h11); put(8'h1A, 8'h90); put(8'h1B, 8'h20);
        put(8'h1C, 8'h10); put(8'h1D, 8'hCC); put(8'h1E, 8'hC0); put(8'h1F, 8'hF0);
        put(8'h20, 8'h40); put(8'h21, 8'h00); put(8'h22, 8'h90); put(8'h23, 8'h1C);
        put(8'h24, 8'hC0); put(8'h25, 8'h80); put(8'h26, 8'h2A); put(8'h27, 8'h10);
        put(8'h28, 8'hDD); put(8'h29, 8'hF0); put(8'h2A, 8'hC0); put(8'h2B, 8'hF0);
        run_prog(1);
        chk("R10 output count", out_cnt, 2);
        chk("R9 R10 branch path result", outs[0], 8'h12);
        chk("R10 JMP target", outs[1], 8'h12);
    endtask

    task automatic t_logic();
        clear_img();
        put(8'h00, 8'h10); put(8'h01, 8'hF0); put(8'h02, 8'h50); put(8'h03, 8'h3C);
        put(8'h04, 8'hC0); put(8'h05, 8'h60); put(8'h06, 8'h0F); put(8'h07, 8'hC0);
        put(8'h08, 8'h70); put(8'h09, 8'hFF); put(8'h0A, 8'hC0); put(8'h0B, 8'h50);
        put(8'h0C, 8'h00); put(8'h0D, 8'hA0); put(8'h0E, 8'h11); put(8'h0F, 8'hF0);
        put(8'h10, 8'hF0); put(8'h11, 8'hC0); put(8'h12, 8'hF0);
        run_prog(0);
        chk("R9 output count", out_cnt, 4);
        chk("R9 AND", outs[0], 8'h30);
        chk("R9 OR", outs[1], 8'h3F);
        chk("R9 XOR", outs[2], 8'hC0);
        chk("R8 zero flag from AND", outs[3], 8'h00);
    endtask

    task automatic t_misc_halt();
        int reqs = 0;
        clear_img();
        put(8'h00, 8'hB0); put(8'h01, 8'h00); put(8'h02, 8'hE0); put(8'h03, 8'hC0);
        put(8'h04, 8'hF0);
        in_data = 8'h9C;
        run_prog(2);
        chk("R3 R12 output count", out_cnt, 1);
        chk("R12 IN then OUT", outs[0], 8'h9C);
        repeat (12) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk("R13 no request after halt", reqs, 0);
        chk("R13 halted stays high", halted, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_img();
        t_reset();
        t_imm_add();
        t_dir_ind_store();
        t_sprel();
        t_branch();
        t_logic();
        t_misc_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule